// File: doc/BRIEF.md
# Fast-Clear Tile State Tracker

This block keeps a small status code for every 8x8-pixel tile of a colour render target window, so that a whole-surface clear costs one cycle instead of a full pass over pixel memory. A clear command only marks every tile as stale. Pixel reads that land in a stale tile get the programmed clear colour instead of the memory word, with the same timing as a normal read. The real clear is deferred: either an explicit eliminate command walks the window and writes the clear colour into every stale tile, or a render write into a stale tile first merges the clear colour into the other 63 pixels of that tile.

The default window is 256x128 pixels (32x16 tiles, 512 codes of 4 bits, 256 bytes of state). Surfaces larger than the window are handled by padding to whole windows outside this block. Pixel memory is addressed linearly as `{y, x}`. The command and memory-write interfaces use valid/ready handshakes; a transfer happens on a rising clock edge where both are high. `cmd_ready_o` is low while a write-out sequence is running, and `mem_wr_valid_o` with its address and data holds steady while `mem_wr_ready_i` is low.

Top module: `fc_tile_tracker`

## Requirements
- R1: After reset every tile is valid, `cmd_ready_o` is 1, `mem_wr_valid_o` is 0, `elim_done_o` is 0, and reads return `mem_rd_data_i`.
- R2: A clear command (`cmd_op_i` = 1) is accepted in one cycle, issues no memory write, and leaves every tile stale.
- R3: A read requested with `rd_en_i` returns, combinationally in the following cycle, the current clear colour if the addressed tile is stale and `mem_rd_data_i` otherwise.
- R4: The clear colour is `{alpha, rgb}`: a register write with `reg_sel_i` = 0 loads bits 23:0 from `reg_wdata_i[23:0]`; with `reg_sel_i` = 1 it loads bits 31:24 from `reg_wdata_i[7:0]`.
- R5: A render write (`cmd_op_i` = 2) to a valid tile issues exactly one memory write of `cmd_data_i` to its pixel.
- R6: A render write to a stale tile issues 64 writes covering that tile in row-major order (x fastest); the addressed pixel gets `cmd_data_i`, the rest the clear colour; afterwards the tile is valid.
- R7: An eliminate command (`cmd_op_i` = 3) visits tiles in ascending index (index = tile row * tiles per row + tile column), writes 64 clear-colour pixels per stale tile in row-major order, none for valid tiles, and leaves all tiles valid.
- R8: `elim_done_o` pulses for exactly one cycle when an eliminate command ends, also when no tile was stale.
- R9: While `mem_wr_valid_o` is high and `mem_wr_ready_i` low, address and data stay stable; `cmd_ready_o` is low until a write-out sequence has finished.
- R10: The memory address of pixel (x, y) is `y * WIN_W + x`, i.e. `{y, x}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Clear-colour register write strobe |
| reg_sel_i | input | 1 | 0 selects rgb, 1 selects alpha |
| reg_wdata_i | input | 24 | Register write data |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready |
| cmd_op_i | input | 2 | 1 clear, 2 render write, 3 eliminate, 0 no-op |
| cmd_x_i | input | X_W | Render write pixel column |
| cmd_y_i | input | Y_W | Render write pixel row |
| cmd_data_i | input | 32 | Render write pixel data |
| mem_wr_valid_o | output | 1 | Memory write valid |
| mem_wr_ready_i | input | 1 | Memory write ready |
| mem_wr_addr_o | output | ADDR_W | Memory write pixel address |
| mem_wr_data_o | output | 32 | Memory write data |
| rd_en_i | input | 1 | Pixel read request |
| rd_x_i | input | X_W | Read pixel column |
| rd_y_i | input | Y_W | Read pixel row |
| mem_rd_data_i | input | 32 | Memory read data, one cycle after the request |
| rd_data_o | output | 32 | Read data after clear-colour substitution |
| elim_done_o | output | 1 | One-cycle pulse at the end of an eliminate |

## Verification
A wrong tile code shows at the read port in the very next cycle after a read to that tile: a stale code that should be valid hides freshly merged pixels behind the clear colour, and a valid code that should be stale leaks memory contents. During an eliminate the same fault changes the count and order of memory writes, which the bench compares address by address against the expected tile walk, and a tile left stale afterwards is caught by a follow-up read. Stalls on the memory write port are inserted to show that no beat is dropped or repeated.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_CLEAR = 2'd1,
    OP_WRITE = 2'd2,
    OP_ELIM  = 2'd3
  } fc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_BURST  = 2'd2,
    ST_SINGLE = 2'd3
  } fc_state_e;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_STALE = '0;
  localparam logic [CODE_W-1:0] CODE_VALID = '1;
endpackage

// File: rtl/fc_color_regs.sv
module fc_color_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic        sel_i,
  input  logic [23:0] wdata_i,
  output logic [31:0] color_o
);
  logic [23:0] rgb_q;
  logic [7:0]  alpha_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_q   <= '0;
      alpha_q <= '0;
    end else if (we_i) begin
      if (sel_i) alpha_q <= wdata_i[7:0];
      else       rgb_q   <= wdata_i;
    end
  end

  assign color_o = {alpha_q, rgb_q};
endmodule

// File: rtl/fc_meta_store.sv
module fc_meta_store
  import fc_pkg::*;
#(
  parameter int NTILES = 512,
  parameter int IDX_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all_i,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [IDX_W-1:0] idx_a_i,
  output logic             stale_a_o,
  input  logic [IDX_W-1:0] idx_b_i,
  output logic             stale_b_o
);
  logic [CODE_W-1:0] code_q [NTILES];

  for (genvar t = 0; t < NTILES; t++) begin : g_tile
    always_ff @(posedge clk) begin
      if (!rst_n)
        code_q[t] <= CODE_VALID;
      else if (clr_all_i)
        code_q[t] <= CODE_STALE;
      else if (set_en_i && (set_idx_i == IDX_W'(t)))
        code_q[t] <= CODE_VALID;
    end
  end

  assign stale_a_o = (code_q[idx_a_i] == CODE_STALE);
  assign stale_b_o = (code_q[idx_b_i] == CODE_STALE);

  // R6/R7: the engine only marks valid a tile it found stale
  a_r6_set_from_stale: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |-> (code_q[set_idx_i] == CODE_STALE));
  // R2: a clear never coincides with a tile update
  a_r2_clear_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |-> !set_en_i);
endmodule

// File: rtl/fc_read_path.sv
module fc_read_path #(
  parameter int IDX_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en_i,
  input  logic        stale_i,
  input  logic [31:0] color_i,
  input  logic [31:0] mem_rd_data_i,
  output logic [31:0] rd_data_o
);
  logic hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       hit_q <= 1'b0;
    else if (rd_en_i) hit_q <= stale_i;
  end

  assign rd_data_o = hit_q ? color_i : mem_rd_data_i;
endmodule

// File: rtl/fc_wb_engine.sv
module fc_wb_engine
  import fc_pkg::*;
#(
  parameter int X_W      = 8,
  parameter int Y_W      = 7,
  parameter int T_LOG2   = 3,
  localparam int TX_W    = X_W - T_LOG2,
  localparam int TY_W    = Y_W - T_LOG2,
  localparam int IDX_W   = TX_W + TY_W,
  localparam int PIX_W   = 2 * T_LOG2,
  localparam int ADDR_W  = X_W + Y_W,
  localparam int NTILES  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [X_W-1:0]    cmd_x_i,
  input  logic [Y_W-1:0]    cmd_y_i,
  input  logic [31:0]       cmd_data_i,
  input  logic [31:0]       color_i,
  output logic [IDX_W-1:0]  look_idx_o,
  input  logic              look_stale_i,
  output logic              clr_all_o,
  output logic              set_en_o,
  output logic [IDX_W-1:0]  set_idx_o,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [31:0]       mem_wr_data_o,
  output logic              done_o
);
  localparam logic [PIX_W-1:0] PIX_LAST  = '1;
  localparam logic [IDX_W-1:0] TILE_LAST = IDX_W'(NTILES - 1);

  fc_state_e        state_q;
  logic [IDX_W-1:0] tile_q;
  logic [PIX_W-1:0] pix_q;
  logic [PIX_W-1:0] tgt_q;
  logic             elim_q;
  logic [31:0]      wdata_q;
  logic [31:0]      col_q;
  logic             done_q;

  logic             accept;
  logic             fire;
  logic             tile_last;
  logic [IDX_W-1:0] cmd_tile;
  logic [PIX_W-1:0] pix_sel;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign cmd_tile    = {cmd_y_i[Y_W-1:T_LOG2], cmd_x_i[X_W-1:T_LOG2]};
  assign look_idx_o  = (state_q == ST_IDLE) ? cmd_tile : tile_q;
  assign tile_last   = (tile_q == TILE_LAST);

  assign mem_wr_valid_o = (state_q == ST_BURST) || (state_q == ST_SINGLE);
  assign fire           = mem_wr_valid_o && mem_wr_ready_i;

  assign clr_all_o = accept && (fc_op_e'(cmd_op_i) == OP_CLEAR);
  assign set_en_o  = (state_q == ST_BURST) && fire && (pix_q == PIX_LAST);
  assign set_idx_o = tile_q;

  // Address is {y, x}: tile row, pixel row, tile column, pixel column
  assign pix_sel       = (state_q == ST_SINGLE) ? tgt_q : pix_q;
  assign mem_wr_addr_o = {tile_q[IDX_W-1:TX_W], pix_sel[PIX_W-1:T_LOG2],
                          tile_q[TX_W-1:0],     pix_sel[T_LOG2-1:0]};
  assign mem_wr_data_o = ((state_q == ST_BURST) && (elim_q || (pix_q != tgt_q)))
                         ? col_q : wdata_q;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tile_q  <= '0;
      pix_q   <= '0;
      tgt_q   <= '0;
      elim_q  <= 1'b0;
      wdata_q <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            unique case (fc_op_e'(cmd_op_i))
              OP_ELIM: begin
                elim_q  <= 1'b1;
                col_q   <= color_i;
                tile_q  <= '0;
                state_q <= ST_SCAN;
              end
              OP_WRITE: begin
                elim_q  <= 1'b0;
                col_q   <= color_i;
                wdata_q <= cmd_data_i;
                tile_q  <= cmd_tile;
                tgt_q   <= {cmd_y_i[T_LOG2-1:0], cmd_x_i[T_LOG2-1:0]};
                pix_q   <= '0;
                state_q <= look_stale_i ? ST_BURST : ST_SINGLE;
              end
              default: ;
            endcase
          end
        end
        ST_SCAN: begin
          if (look_stale_i) begin
            pix_q   <= '0;
            state_q <= ST_BURST;
          end else if (tile_last) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tile_q <= tile_q + 1'b1;
          end
        end
        ST_BURST: begin
          if (fire) begin
            if (pix_q == PIX_LAST) begin
              if (!elim_q) begin
                state_q <= ST_IDLE;
              end else if (tile_last) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                tile_q  <= tile_q + 1'b1;
                state_q <= ST_SCAN;
              end
            end else begin
              pix_q <= pix_q + 1'b1;
            end
          end
        end
        ST_SINGLE: begin
          if (fire) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled beat keeps its address and data
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: done only follows an eliminate walk
  a_r8_done_after_elim: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (elim_q && ($past(state_q) != ST_IDLE)));
  // R9: no command is taken while writes are outstanding
  a_r9_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid_o |-> !cmd_ready_o);
endmodule

// File: rtl/fc_tile_tracker.sv
module fc_tile_tracker
  import fc_pkg::*;
#(
  parameter int WIN_W  = 256,
  parameter int WIN_H  = 128,
  parameter int T_LOG2 = 3,
  localparam int X_W    = $clog2(WIN_W),
  localparam int Y_W    = $clog2(WIN_H),
  localparam int ADDR_W = X_W + Y_W,
  localparam int IDX_W  = X_W + Y_W - 2 * T_LOG2,
  localparam int NTILES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [23:0]       reg_wdata_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [X_W-1:0]    cmd_x_i,
  input  logic [Y_W-1:0]    cmd_y_i,
  input  logic [31:0]       cmd_data_i,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [31:0]       mem_wr_data_o,
  input  logic              rd_en_i,
  input  logic [X_W-1:0]    rd_x_i,
  input  logic [Y_W-1:0]    rd_y_i,
  input  logic [31:0]       mem_rd_data_i,
  output logic [31:0]       rd_data_o,
  output logic              elim_done_o
);
  logic [31:0]      color;
  logic [IDX_W-1:0] look_idx;
  logic             look_stale;
  logic             clr_all;
  logic             set_en;
  logic [IDX_W-1:0] set_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_stale;

  assign rd_idx = {rd_y_i[Y_W-1:T_LOG2], rd_x_i[X_W-1:T_LOG2]};

  fc_color_regs u_color (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .color_o (color)
  );

  fc_meta_store #(.NTILES(NTILES), .IDX_W(IDX_W)) u_meta (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all_i (clr_all),
    .set_en_i  (set_en),
    .set_idx_i (set_idx),
    .idx_a_i   (look_idx),
    .stale_a_o (look_stale),
    .idx_b_i   (rd_idx),
    .stale_b_o (rd_stale)
  );

  fc_wb_engine #(.X_W(X_W), .Y_W(Y_W), .T_LOG2(T_LOG2)) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_ready_o    (cmd_ready_o),
    .cmd_op_i       (cmd_op_i),
    .cmd_x_i        (cmd_x_i),
    .cmd_y_i        (cmd_y_i),
    .cmd_data_i     (cmd_data_i),
    .color_i        (color),
    .look_idx_o     (look_idx),
    .look_stale_i   (look_stale),
    .clr_all_o      (clr_all),
    .set_en_o       (set_en),
    .set_idx_o      (set_idx),
    .mem_wr_valid_o (mem_wr_valid_o),
    .mem_wr_ready_i (mem_wr_ready_i),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .mem_wr_data_o  (mem_wr_data_o),
    .done_o         (elim_done_o)
  );

  fc_read_path #(.IDX_W(IDX_W)) u_read (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en_i       (rd_en_i),
    .stale_i       (rd_stale),
    .color_i       (color),
    .mem_rd_data_i (mem_rd_data_i),
    .rd_data_o     (rd_data_o)
  );

  // R2: a clear issues no memory write in the cycle it is taken
  a_r2_clear_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |-> !mem_wr_valid_o);
  // R1: the engine output is idle right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (cmd_ready_o && !mem_wr_valid_o && !elim_done_o));
endmodule

// File: tb/fc_tile_tracker_test.sv
module fc_tile_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 256;
  localparam int TPR = 32;   // tiles per row
  localparam int NT = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [7:0]  cmd_x = '0;
  logic [6:0]  cmd_y = '0;
  logic [31:0] cmd_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [14:0] wr_addr;
  logic [31:0] wr_data;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_x = '0;
  logic [6:0]  rd_y = '0;
  logic [31:0] mem_rd = '0;
  logic [31:0] rd_data;
  logic        done;

  int checks = 0, fails = 0;
  int done_cnt = 0;
  bit stall_en = 1'b0;
  int stall_cnt = 0;
  int log_addr[$];
  logic [31:0] log_data[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_tile_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_x_i(cmd_x), .cmd_y_i(cmd_y), .cmd_data_i(cmd_data),
    .mem_wr_valid_o(wr_valid), .mem_wr_ready_i(wr_ready),
    .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .rd_en_i(rd_en), .rd_x_i(rd_x), .rd_y_i(rd_y),
    .mem_rd_data_i(mem_rd), .rd_data_o(rd_data), .elim_done_o(done)
  );

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      log_addr.push_back(int'(wr_addr));
      log_data.push_back(wr_data);
    end
    if (rst_n && done) done_cnt++;
  end

  always @(negedge clk) begin
    stall_cnt++;
    wr_ready <= stall_en ? ((stall_cnt % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input bit sel, input logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input int x, input int y, input logic [31:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_x = 8'(x); cmd_y = 7'(y); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input int x, input int y, input logic [31:0] memv, output logic [31:0] got);
    @(negedge clk);
    rd_en = 1'b1; rd_x = 8'(x); rd_y = 7'(y);
    @(negedge clk);
    rd_en = 1'b0; mem_rd = memv;
    #1 got = rd_data;
  endtask

  function automatic int pix_addr(input int tile, input int p);
    return ((tile / TPR) * 8 + p / 8) * W + (tile % TPR) * 8 + p % 8;
  endfunction

  task automatic t_reset();
    logic [31:0] g;
    check(cmd_ready === 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
    check(wr_valid === 1'b0, "R1 wr_valid", 32'(wr_valid), 0);
    check(done === 1'b0, "R1 done", 32'(done), 0);
    do_read(100, 50, 32'hDEAD_0001, g);
    check(g == 32'hDEAD_0001, "R1 read passthrough", g, 32'hDEAD_0001);
  endtask

  task automatic t_clear();
    logic [31:0] g;
    int n0;
    set_reg(1'b0, 24'h123456);
    set_reg(1'b1, 24'h000078);
    n0 = log_addr.size();
    issue(2'd1, 0, 0, '0);
    repeat (3) @(negedge clk);
    check(log_addr.size() == n0, "R2 clear writes none", 32'(log_addr.size() - n0), 0);
    check(cmd_ready === 1'b1, "R2 clear one cycle", 32'(cmd_ready), 1);
    do_read(0, 0, 32'hAAAA_0000, g);
    check(g == 32'h7812_3456, "R4 colour order / R3 stale read", g, 32'h7812_3456);
    do_read(255, 127, 32'hAAAA_0001, g);
    check(g == 32'h7812_3456, "R2 last tile stale", g, 32'h7812_3456);
    set_reg(1'b1, 24'hFFFF9A);
    do_read(77, 33, 32'hAAAA_0002, g);
    check(g == 32'h9A12_3456, "R4 alpha low byte / R3 live colour", g, 32'h9A12_3456);
  endtask

  task automatic t_merge();
    logic [31:0] g;
    int n0, bad;
    n0 = log_addr.size();
    stall_en = 1'b1;
    issue(2'd2, 13, 21, 32'hC0FF_EE00);
    check(cmd_ready === 1'b0, "R9 busy during merge", 32'(cmd_ready), 0);
    wait_idle();
    stall_en = 1'b0;
    check(log_addr.size() - n0 == 64, "R6 merge beat count", 32'(log_addr.size() - n0), 64);
    bad = 0;
    for (int p = 0; p < 64 && n0 + p < log_addr.size(); p++) begin
      int ea;
      logic [31:0] ed;
      ea = pix_addr(65, p);
      ed = (p == 5 * 8 + 5) ? 32'hC0FF_EE00 : 32'h9A12_3456;
      if (log_addr[n0+p] != ea || log_data[n0+p] != ed) begin
        if (bad == 0) check(1'b0, "R6/R10 merge beat", log_data[n0+p], ed);
        bad++;
      end
    end
    check(bad == 0, "R6 merge content", 32'(bad), 0);
    do_read(13, 21, 32'h5555_1111, g);
    check(g == 32'h5555_1111, "R6 tile valid after merge", g, 32'h5555_1111);
    do_read(8, 23, 32'h5555_2222, g);
    check(g == 32'h5555_2222, "R6 tile corner valid", g, 32'h5555_2222);
    do_read(16, 21, 32'h5555_3333, g);
    check(g == 32'h9A12_3456, "R3 neighbour still stale", g, 32'h9A12_3456);
  endtask

  task automatic t_single();
    int n0;
    n0 = log_addr.size();
    issue(2'd2, 13, 21, 32'h0BAD_F00D);
    wait_idle();
    check(log_addr.size() - n0 == 1, "R5 single beat", 32'(log_addr.size() - n0), 1);
    if (log_addr.size() > n0) begin
      check(log_addr[n0] == 21 * W + 13, "R10 address y*W+x", 32'(log_addr[n0]), 32'(21 * W + 13));
      check(log_data[n0] == 32'h0BAD_F00D, "R5 single data", log_data[n0], 32'h0BAD_F00D);
    end
  endtask

  task automatic t_elim();
    logic [31:0] g;
    int n0, d0, k, bad;
    n0 = log_addr.size();
    d0 = done_cnt;
    stall_en = 1'b1;
    issue(2'd3, 0, 0, '0);
    wait_idle();
    stall_en = 1'b0;
    repeat (2) @(negedge clk);
    check(log_addr.size() - n0 == (NT - 1) * 64, "R7 eliminate beat count",
          32'(log_addr.size() - n0), 32'((NT - 1) * 64));
    check(done_cnt - d0 == 1, "R8 one done pulse", 32'(done_cnt - d0), 1);
    bad = 0;
    k = n0;
    for (int t = 0; t < NT; t++) begin
      if (t == 65) continue;
      for (int p = 0; p < 64; p++) begin
        if (k < log_addr.size()) begin
          if (log_addr[k] != pix_addr(t, p) || log_data[k] != 32'h9A12_3456) begin
            if (bad == 0) check(1'b0, "R7 walk order/data", 32'(log_addr[k]), 32'(pix_addr(t, p)));
            bad++;
          end
        end
        k++;
      end
    end
    check(bad == 0, "R7 ascending walk", 32'(bad), 0);
    do_read(0, 0, 32'h7777_0000, g);
    check(g == 32'h7777_0000, "R7 tiles valid after", g, 32'h7777_0000);
    do_read(255, 127, 32'h7777_0001, g);
    check(g == 32'h7777_0001, "R7 last tile valid", g, 32'h7777_0001);
  endtask

  task automatic t_elim_empty();
    int n0, d0;
    n0 = log_addr.size();
    d0 = done_cnt;
    issue(2'd3, 0, 0, '0);
    wait_idle();
    repeat (2) @(negedge clk);
    check(log_addr.size() == n0, "R7 no writes when all valid", 32'(log_addr.size() - n0), 0);
    check(done_cnt - d0 == 1, "R8 done with nothing stale", 32'(done_cnt - d0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clear();
    t_merge();
    t_single();
    t_elim();
    t_elim_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule